// File: doc/BRIEF.md
# Machine Interrupt Pending and Enable Unit

This unit holds the machine-level interrupt-enable and interrupt-pending registers of a small core. It serves three interrupt lines. The first is the standard timer interrupt, which follows a timer-match signal from outside the unit. The second is a platform interrupt raised when any general-purpose pin that is set as an input changes level. The third is a platform interrupt raised when a message-received strobe arrives. The two platform interrupts are sticky: each stays pending until software writes a zero to it.

The core reaches both registers through a simple CSR port. A write selects one register and takes effect at the next clock edge. A read is combinational and returns the register that the select line names. The unit drives a single interrupt request to the core. That request is high when any implemented source is both pending and enabled, and only while the core's global machine interrupt enable is set. Turning pending interrupts into a cause code, trap vectoring and the peripherals themselves belong to other blocks.

Top module: `mirq_unit`

## Requirements
- R1: After reset the enable register and both sticky pending bits are zero, and `irq_o` is low.
- R2: Only bit positions 7 (timer), 16 (pin change) and 17 (message) exist in either register. Every other bit reads as zero, and writing to it has no effect.
- R3: Pending bit 7 always equals `tmr_match_i` in the same cycle. A software write to pending bit 7 has no effect.
- R4: A rising or falling level change on a pin whose `pin_dir_i` bit is 0 (input) sets pending bit 16. The bit reads as set after the second rising clock edge that follows the change.
- R5: A level change on a pin whose `pin_dir_i` bit is 1 (output) does not set pending bit 16.
- R6: When `msg_rx_i` is high at a rising clock edge, pending bit 17 reads as set after that edge.
- R7: Pending bits 16 and 17 hold their value until a write to the pending register (`csr_sel_i` = 1) changes them. Writing 0 clears the bit and writing 1 sets it.
- R8: When a set event and a software write of 0 reach the same sticky bit in the same cycle, the bit ends up set.
- R9: `irq_o` equals `gie_i` AND the OR, over bits 7, 16 and 17, of pending AND enable.
- R10: A write to the enable register (`csr_sel_i` = 0) stores bits 7, 16 and 17 of `csr_wdata_i`, and the stored value can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| tmr_match_i | input | 1 | Timer compare match level |
| pin_i | input | NPINS | General-purpose pin levels |
| pin_dir_i | input | NPINS | Per-pin direction, 1 = output, 0 = input |
| msg_rx_i | input | 1 | One-cycle strobe: a message has been received |
| gie_i | input | 1 | Global machine interrupt enable from the core |
| csr_we_i | input | 1 | CSR write strobe |
| csr_sel_i | input | 1 | Register select, 0 = enable, 1 = pending |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | Contents of the selected register |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The pin-change path is driven with both rising and falling edges on input pins, which separates a true change detector from one that sees only one edge. Toggles on pins configured as outputs, including a mix of input and output pins, show that the direction mask is applied per pin. The sticky bits are tested with a pending value left to stand over many idle cycles, with explicit writes of 0 and of 1, and with a message strobe that lands in the same cycle as a clear, which shows which of the two wins. The request output is tried with each gate opened or closed on its own: the global enable, the per-bit enable and the pending state, and the timer level as a source.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
  localparam int XLEN    = 32;
  // Bit positions are decoded by software and must stay fixed.
  localparam int TMR_POS = 7;
  localparam int PIN_POS = 16;
  localparam int MSG_POS = 17;
  localparam int NSRC    = 3;   // timer, pin change, message
  localparam int NSTICKY = 2;   // pin change, message

  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_PEND   = 1'b1
  } mirq_sel_e;

  localparam logic [XLEN-1:0] IMPL_MASK =
    (XLEN'(1) << TMR_POS) | (XLEN'(1) << PIN_POS) | (XLEN'(1) << MSG_POS);
endpackage

// File: rtl/mirq_rst_sync.sv
module mirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/mirq_pin_watch.sv
module mirq_pin_watch #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] pin_dir_i,
  output logic             change_o
);
  logic [NPINS-1:0] smp_q, smp_d;
  logic [NPINS-1:0] old_q, old_d;
  logic [NPINS-1:0] diff;

  always_comb begin
    smp_d = pin_i;
    old_d = smp_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      smp_q <= '0;
      old_q <= '0;
    end else begin
      smp_q <= smp_d;
      old_q <= old_d;
    end
  end

  // Only pins set as inputs take part in change detection.
  always_comb begin
    diff = (smp_q ^ old_q) & ~pin_dir_i;
  end

  assign change_o = |diff;
endmodule

// File: rtl/mirq_sticky.sv
module mirq_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_ns,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic [N-1:0] wval_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic bit_q, bit_d, bit_ce;

    // A set event takes priority over a software write in the same cycle.
    always_comb begin
      bit_ce = set_i[g] | wr_i;
      bit_d  = set_i[g] | wval_i[g];
    end

    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns)     bit_q <= 1'b0;
      else if (bit_ce) bit_q <= bit_d;
    end

    assign q_o[g] = bit_q;
  end
endmodule

// File: rtl/mirq_unit.sv
module mirq_unit
  import mirq_pkg::*;
#(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_match_i,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] pin_dir_i,
  input  logic             msg_rx_i,
  input  logic             gie_i,
  input  logic             csr_we_i,
  input  logic             csr_sel_i,
  input  logic [31:0]      csr_wdata_i,
  output logic [31:0]      csr_rdata_o,
  output logic             irq_o
);
  logic rst_ns;
  logic pin_evt;
  logic wr_en, wr_pend;
  logic [NSRC-1:0]    en_q, en_d;
  logic [NSTICKY-1:0] cust_q;
  logic [NSRC-1:0]    pend_vec;
  logic [NSRC-1:0]    rd_vec;
  logic               unused_wbits;

  mirq_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  mirq_pin_watch #(.NPINS(NPINS)) u_pins (
    .clk       (clk),
    .rst_ns    (rst_ns),
    .pin_i     (pin_i),
    .pin_dir_i (pin_dir_i),
    .change_o  (pin_evt)
  );

  always_comb begin
    wr_en   = csr_we_i & (csr_sel_i == SEL_ENABLE);
    wr_pend = csr_we_i & (csr_sel_i == SEL_PEND);
    en_d    = {csr_wdata_i[MSG_POS], csr_wdata_i[PIN_POS], csr_wdata_i[TMR_POS]};
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)    en_q <= '0;
    else if (wr_en) en_q <= en_d;
  end

  mirq_sticky #(.N(NSTICKY)) u_stk (
    .clk    (clk),
    .rst_ns (rst_ns),
    .set_i  ({msg_rx_i, pin_evt}),
    .wr_i   (wr_pend),
    .wval_i ({csr_wdata_i[MSG_POS], csr_wdata_i[PIN_POS]}),
    .q_o    (cust_q)
  );

  // Timer pending is a live mirror of the match level.
  assign pend_vec = {cust_q, tmr_match_i};

  always_comb begin
    rd_vec               = (csr_sel_i == SEL_PEND) ? pend_vec : en_q;
    csr_rdata_o          = '0;
    csr_rdata_o[TMR_POS] = rd_vec[0];
    csr_rdata_o[PIN_POS] = rd_vec[1];
    csr_rdata_o[MSG_POS] = rd_vec[2];
  end

  assign irq_o = gie_i & (|(pend_vec & en_q));

  assign unused_wbits = ^csr_wdata_i;
endmodule

// File: rtl/mirq_unit_chk.sv
module mirq_unit_chk
  import mirq_pkg::*;
(
  input logic        clk,
  input logic        rst_ns,
  input logic        tmr_match_i,
  input logic        msg_rx_i,
  input logic        gie_i,
  input logic        csr_we_i,
  input logic        csr_sel_i,
  input logic [31:0] csr_wdata_i,
  input logic [31:0] csr_rdata_o,
  input logic        irq_o,
  input logic [2:0]  pend_vec,
  input logic [2:0]  en_q
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_ns)
    (csr_rdata_o & ~IMPL_MASK) == '0); // R2
  AST_TMR_MIRROR: assert property (@(posedge clk) disable iff (!rst_ns)
    csr_sel_i |-> csr_rdata_o[TMR_POS] == tmr_match_i); // R3
  AST_MSG_SET: assert property (@(posedge clk) disable iff (!rst_ns)
    msg_rx_i |=> pend_vec[2]); // R6
  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    pend_vec[1] && !(csr_we_i && csr_sel_i && !csr_wdata_i[PIN_POS]) |=> pend_vec[1]); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_ns)
    msg_rx_i && csr_we_i && csr_sel_i && !csr_wdata_i[MSG_POS] |=> pend_vec[2]); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_ns)
    !gie_i |-> !irq_o); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_ns)
    ((pend_vec & en_q) == '0) |-> !irq_o); // R9
  AST_EN_STORE: assert property (@(posedge clk) disable iff (!rst_ns)
    csr_we_i && !csr_sel_i |=> en_q[0] == $past(csr_wdata_i[TMR_POS])); // R10
endmodule

bind mirq_unit mirq_unit_chk u_chk (
  .clk         (clk),
  .rst_ns      (rst_ns),
  .tmr_match_i (tmr_match_i),
  .msg_rx_i    (msg_rx_i),
  .gie_i       (gie_i),
  .csr_we_i    (csr_we_i),
  .csr_sel_i   (csr_sel_i),
  .csr_wdata_i (csr_wdata_i),
  .csr_rdata_o (csr_rdata_o),
  .irq_o       (irq_o),
  .pend_vec    (pend_vec),
  .en_q        (en_q)
);

// File: tb/mirq_unit_tb.sv
module mirq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_match_i = 1'b0;
  logic [3:0]  pin_i = '0;
  logic [3:0]  pin_dir_i = '0;
  logic        msg_rx_i = 1'b0;
  logic        gie_i = 1'b0;
  logic        csr_we_i = 1'b0;
  logic        csr_sel_i = 1'b0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] B7  = 32'h0000_0080;
  localparam logic [31:0] B16 = 32'h0001_0000;
  localparam logic [31:0] B17 = 32'h0002_0000;

  always #10 clk = ~clk;

  mirq_unit #(.NPINS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_match_i(tmr_match_i), .pin_i(pin_i),
    .pin_dir_i(pin_dir_i), .msg_rx_i(msg_rx_i), .gie_i(gie_i),
    .csr_we_i(csr_we_i), .csr_sel_i(csr_sel_i), .csr_wdata_i(csr_wdata_i),
    .csr_rdata_o(csr_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic sel, input logic [31:0] data);
    @(negedge clk);
    csr_we_i = 1'b1; csr_sel_i = sel; csr_wdata_i = data;
    @(negedge clk);
    csr_we_i = 1'b0; csr_wdata_i = '0;
  endtask

  task automatic csr_rd(input logic sel, output logic [31:0] data);
    csr_sel_i = sel;
    #1;
    data = csr_rdata_o;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    csr_rd(1'b0, v); chk("R1 enable after reset", v, 32'h0);
    csr_rd(1'b1, v); chk("R1 pending after reset", v, 32'h0);
    chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    csr_wr(1'b0, 32'hFFFF_FFFF);
    csr_rd(1'b0, v); chk("R10 R2 enable all ones", v, B7 | B16 | B17);
    csr_wr(1'b0, B16);
    csr_rd(1'b0, v); chk("R10 enable single bit", v, B16);
    csr_wr(1'b0, 32'h0);
    csr_rd(1'b0, v); chk("R10 enable cleared", v, 32'h0);
  endtask

  task automatic t_rsvd;
    logic [31:0] v;
    csr_wr(1'b1, 32'hFFFC_FFFF);
    csr_rd(1'b1, v); chk("R2 R3 reserved and timer bits ignore pending write", v, 32'h0);
  endtask

  task automatic t_timer;
    logic [31:0] v;
    @(negedge clk); tmr_match_i = 1'b1;
    csr_rd(1'b1, v); chk("R3 timer pending follows match high", v, B7);
    csr_wr(1'b1, 32'h0);
    csr_rd(1'b1, v); chk("R3 timer pending ignores write of 0", v, B7);
    tmr_match_i = 1'b0;
    csr_rd(1'b1, v); chk("R3 timer pending follows match low", v, 32'h0);
  endtask

  task automatic t_pin_input;
    logic [31:0] v;
    pin_dir_i = 4'b0000;
    @(negedge clk); pin_i = 4'b0100;
    @(negedge clk); csr_rd(1'b1, v); chk("R4 rising: not yet after one edge", v, 32'h0);
    @(negedge clk); csr_rd(1'b1, v); chk("R4 rising edge sets bit 16", v, B16);
    wait_cyc(6);
    csr_rd(1'b1, v); chk("R7 bit 16 held while idle", v, B16);
    csr_wr(1'b1, 32'h0);
    csr_rd(1'b1, v); chk("R7 bit 16 cleared by write 0", v, 32'h0);
    @(negedge clk); pin_i = 4'b0000;
    wait_cyc(2);
    csr_rd(1'b1, v); chk("R4 falling edge sets bit 16", v, B16);
    csr_wr(1'b1, 32'h0);
  endtask

  task automatic t_pin_output;
    logic [31:0] v;
    @(negedge clk); pin_dir_i = 4'b1111;
    pin_i = 4'b1011;
    wait_cyc(3);
    pin_i = 4'b0000;
    wait_cyc(3);
    csr_rd(1'b1, v); chk("R5 output pin toggles ignored", v, 32'h0);
    pin_dir_i = 4'b1101;
    pin_i = 4'b0100;
    wait_cyc(3);
    csr_rd(1'b1, v); chk("R5 toggle on output pin among mixed", v, 32'h0);
    pin_i = 4'b0110;
    wait_cyc(2);
    csr_rd(1'b1, v); chk("R4 toggle on input pin among mixed", v, B16);
    csr_wr(1'b1, 32'h0);
    pin_dir_i = 4'b1111;
    pin_i = 4'b0000;
    wait_cyc(3);
  endtask

  task automatic t_msg;
    logic [31:0] v;
    @(negedge clk); msg_rx_i = 1'b1;
    @(negedge clk); msg_rx_i = 1'b0;
    csr_rd(1'b1, v); chk("R6 message sets bit 17", v, B17);
    wait_cyc(8);
    csr_rd(1'b1, v); chk("R7 bit 17 held", v, B17);
    csr_wr(1'b1, B17);
    csr_rd(1'b1, v); chk("R7 write 1 keeps bit 17", v, B17);
    csr_wr(1'b1, 32'h0);
    csr_rd(1'b1, v); chk("R7 write 0 clears bit 17", v, 32'h0);
    csr_wr(1'b1, B16);
    csr_rd(1'b1, v); chk("R7 write 1 sets bit 16", v, B16);
    csr_wr(1'b1, 32'h0);
  endtask

  task automatic t_race;
    logic [31:0] v;
    @(negedge clk);
    msg_rx_i = 1'b1; csr_we_i = 1'b1; csr_sel_i = 1'b1; csr_wdata_i = 32'h0;
    @(negedge clk);
    msg_rx_i = 1'b0; csr_we_i = 1'b0;
    csr_rd(1'b1, v); chk("R8 set wins over same-cycle clear", v, B17);
    csr_wr(1'b1, 32'h0);
  endtask

  task automatic t_irq;
    csr_wr(1'b0, B17);
    @(negedge clk); msg_rx_i = 1'b1;
    @(negedge clk); msg_rx_i = 1'b0; gie_i = 1'b0;
    #1; chk("R9 irq blocked by global enable", {31'h0, irq_o}, 32'h0);
    gie_i = 1'b1;
    #1; chk("R9 irq raised by pending and enabled", {31'h0, irq_o}, 32'h1);
    csr_wr(1'b0, B16 | B7);
    #1; chk("R9 irq masked by per-bit enable", {31'h0, irq_o}, 32'h0);
    tmr_match_i = 1'b1;
    #1; chk("R9 irq from timer", {31'h0, irq_o}, 32'h1);
    tmr_match_i = 1'b0;
    #1; chk("R9 irq drops with timer level", {31'h0, irq_o}, 32'h0);
    gie_i = 1'b0;
    csr_wr(1'b1, 32'h0);
    csr_wr(1'b0, 32'h0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_enable();
    t_rsvd();
    t_timer();
    t_pin_input();
    t_pin_output();
    t_msg();
    t_race();
    t_irq();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule